// File: doc/BRIEF.md
# Page Zero Auto-Index Address Generator

This block turns the operand fields of a memory-reference instruction into a short series of memory cycles. The fields are a 10-bit operand, an indirect bit and a register bit; the register bit selects page zero instead of the current page. A direct operand produces one access. An indirect operand first fetches a 16-bit pointer and then accesses the data the pointer names. The top 256 cells of page zero act as pointer registers with side effects. When one of these cells is used indirectly in register mode, two fields of the operand decide its behaviour. One field picks an update rule: none, increment after use, decrement after use, or stack. The other field picks which of the eight bank registers qualifies the final data access.

A controller pulses `go` with the fields latched on its inputs. The block then runs each step as a request/acknowledge handshake on a simple memory port. Each request carries a 16-bit address, a 3-bit bank index, a write flag and write data. When the sequence is finished the block raises `done` for one cycle. At that point `ea` and `ea_bank` hold the address and bank of the data access, and `rd_data` holds the word read (on reads).

Top module: `pzag_top`

## Requirements
- R1: With the indirect bit clear and the register bit set, exactly one access is issued. Its address is the operand zero-extended to 16 bits, its bank index is 3 (page-zero bank), and its write flag equals `wr_dir`.
- R2: With the indirect bit clear and the register bit clear, exactly one access is issued at address {`pc_hi`, operand} with bank index 0 (program bank).
- R3: An indirect access to an ordinary cell does two things. A cell is ordinary when the register bit is clear, or when the register bit is set and the operand is below 0x300. The block first reads the pointer at the composed address, using bank 3 in register mode and bank 0 otherwise. It then accesses the data at the pointer value with bank index 1 (indirect-data bank). No write-back is made.
- R4: A register-mode indirect operand of the form binary 11 TT XXX BBB (operand ≥ 0x300) is a pointer cell. Bits 7:6 are TT and bits 2:0 are BBB. The pointer is read from page zero (bank 3) at the operand address, and the data access uses bank index BBB. With TT=00 no write-back follows.
- R5: With TT=01 the data access at the pointer is followed by a write of pointer+1 to the same page-zero cell (bank 3).
- R6: With TT=10 the data access at the pointer is followed by a write of pointer−1 to the same page-zero cell.
- R7: With TT=11 on a read, pointer−1 is first written to the cell, and then the data is read at pointer−1.
- R8: With TT=11 on a write, the data is written at the pointer, and then pointer+1 is written to the cell.
- R9: All pointer updates wrap modulo 2^16 (0xFFFF+1 = 0x0000, 0x0000−1 = 0xFFFF).
- R10: Each step holds its request, address, bank, write flag and write data steady until acknowledged. `done` pulses for one cycle, one cycle after the last acknowledge. At that point `ea`/`ea_bank` give the data-access address and bank, and `rd_data` gives the word read. After reset no request is pending and `busy`/`done` are low.
- R11: While a sequence is in progress, `go` and all field inputs are ignored. The sequence issues exactly the steps of the operation that started it, and no further request follows its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, sampled only when idle |
| opd | input | 10 | Instruction operand field |
| ind_bit | input | 1 | Indirect addressing bit |
| reg_bit | input | 1 | Register (page zero) bit |
| pc_hi | input | 6 | Upper six bits of the program counter |
| wr_dir | input | 1 | 1 = final access writes, 0 = reads |
| wr_data | input | 16 | Data for the final write access |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address within the bank |
| mem_bank | output | 3 | Bank register index for the request |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge, ends the current step |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Address of the last data access |
| ea_bank | output | 3 | Bank index of the last data access |
| rd_data | output | 16 | Word returned by the last data read |

## Verification
The hardest case to reach is the stack cell used as a push/pop pair. A read must write the decremented pointer back before the data read uses that same decremented value. A following write must then land where the read came from and restore the cell. The stimulus runs a pop, a push and a second pop against one cell. Between operations the pointer value lives only in the bench memory, so every step's address and write data are checked against values the bench predicted. Wrap at 0x0000 and 0xFFFF is reached by preloading pointer cells with those values. Acknowledge delays are varied so that requests must hold for several cycles. A stray `go` with different fields is injected mid-sequence.

// File: rtl/pzag_pkg.sv
package pzag_pkg;

    localparam int BANK_W = 3;

    localparam logic [BANK_W-1:0] BANK_PROG = 3'd0;
    localparam logic [BANK_W-1:0] BANK_IND  = 3'd1;
    localparam logic [BANK_W-1:0] BANK_PZ   = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PTR  = 3'd1,
        ST_PRE  = 3'd2,
        ST_DATA = 3'd3,
        ST_POST = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        PK_PLAIN = 2'b00,
        PK_INC   = 2'b01,
        PK_DEC   = 2'b10,
        PK_STACK = 2'b11
    } ptr_kind_e;

endpackage

// File: rtl/pzag_decode.sv
module pzag_decode
    import pzag_pkg::*;
#(
    parameter int OPW = 10,
    parameter int AW  = 16
) (
    input  logic [OPW-1:0]          opd_l,
    input  logic                    ind_l,
    input  logic                    reg_l,
    input  logic [AW-OPW-1:0]       pchi_l,
    input  logic                    wr_l,
    output logic [AW-1:0]           first_addr,
    output logic [BANK_W-1:0]       first_bank,
    output logic                    special,
    output logic [BANK_W-1:0]       sel_bank,
    output logic                    has_pre,
    output logic                    has_post,
    output logic                    post_up
);
    localparam int HIW = AW - OPW;

    ptr_kind_e kind;

    always_comb begin
        first_addr = reg_l ? {{HIW{1'b0}}, opd_l} : {pchi_l, opd_l};
        first_bank = reg_l ? BANK_PZ : BANK_PROG;
        special    = reg_l && ind_l && (opd_l[OPW-1:OPW-2] == 2'b11);
        kind       = ptr_kind_e'(opd_l[OPW-3:OPW-4]);
        sel_bank   = opd_l[BANK_W-1:0];
        has_pre    = special && (kind == PK_STACK) && !wr_l;
        has_post   = special && ((kind == PK_INC) || (kind == PK_DEC) ||
                                 ((kind == PK_STACK) && wr_l));
        post_up    = (kind == PK_INC) || (kind == PK_STACK);
    end

endmodule

// File: rtl/pzag_ptr_step.sv
module pzag_ptr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic          up,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    always_comb begin
        nxt = up ? (ptr + ONE) : (ptr - ONE);
    end

endmodule

// File: rtl/pzag_seq.sv
module pzag_seq
    import pzag_pkg::*;
#(
    parameter int OPW = 10,
    parameter int AW  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [OPW-1:0]      opd,
    input  logic                ind_bit,
    input  logic                reg_bit,
    input  logic [AW-OPW-1:0]   pc_hi,
    input  logic                wr_dir,
    input  logic [AW-1:0]       wr_data,
    input  logic [AW-1:0]       first_addr,
    input  logic [BANK_W-1:0]   first_bank,
    input  logic                special,
    input  logic [BANK_W-1:0]   sel_bank,
    input  logic                has_pre,
    input  logic                has_post,
    input  logic                post_up,
    output logic [OPW-1:0]      opd_l,
    output logic                ind_l,
    output logic                reg_l,
    output logic [AW-OPW-1:0]   pchi_l,
    output logic                wr_l,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [BANK_W-1:0]   mem_bank,
    output logic [AW-1:0]       mem_wdata,
    input  logic                mem_ack,
    input  logic [AW-1:0]       mem_rdata,
    output logic                busy,
    output logic                done,
    output logic [AW-1:0]       ea,
    output logic [BANK_W-1:0]   ea_bank,
    output logic [AW-1:0]       rd_data
);
    typedef struct packed {
        step_e               step;
        logic [OPW-1:0]      opd;
        logic                ind;
        logic                rmode;
        logic [AW-OPW-1:0]   pchi;
        logic                wr;
        logic [AW-1:0]       wdat;
        logic [AW-1:0]       ptr;
        logic [AW-1:0]       ea;
        logic [BANK_W-1:0]   eabank;
        logic [AW-1:0]       rdata;
        logic                done;
    } seq_t;

    seq_t s_q, s_d;

    logic          ptr_up;
    logic [AW-1:0] ptr_nxt;

    pzag_ptr_step #(.AW(AW)) u_step (
        .ptr (s_q.ptr),
        .up  (ptr_up),
        .nxt (ptr_nxt)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = first_addr;
        mem_bank  = first_bank;
        mem_wdata = '0;
        ptr_up    = 1'b0;
        unique case (s_q.step)
            ST_IDLE: begin
                if (go) begin
                    s_d.opd   = opd;
                    s_d.ind   = ind_bit;
                    s_d.rmode = reg_bit;
                    s_d.pchi  = pc_hi;
                    s_d.wr    = wr_dir;
                    s_d.wdat  = wr_data;
                    s_d.step  = ind_bit ? ST_PTR : ST_DATA;
                end
            end
            ST_PTR: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.ptr  = mem_rdata;
                    s_d.step = has_pre ? ST_PRE : ST_DATA;
                end
            end
            ST_PRE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_bank  = BANK_PZ;
                mem_wdata = ptr_nxt;
                if (mem_ack) begin
                    s_d.ptr  = ptr_nxt;
                    s_d.step = ST_DATA;
                end
            end
            ST_DATA: begin
                mem_req   = 1'b1;
                mem_we    = s_q.wr;
                mem_wdata = s_q.wdat;
                if (s_q.ind) begin
                    mem_addr = s_q.ptr;
                    mem_bank = special ? sel_bank : BANK_IND;
                end
                if (mem_ack) begin
                    s_d.ea     = mem_addr;
                    s_d.eabank = mem_bank;
                    if (!s_q.wr) begin
                        s_d.rdata = mem_rdata;
                    end
                    if (has_post) begin
                        s_d.step = ST_POST;
                    end else begin
                        s_d.step = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            ST_POST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_bank  = BANK_PZ;
                ptr_up    = post_up;
                mem_wdata = ptr_nxt;
                if (mem_ack) begin
                    s_d.step = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.step <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign opd_l   = s_q.opd;
    assign ind_l   = s_q.ind;
    assign reg_l   = s_q.rmode;
    assign pchi_l  = s_q.pchi;
    assign wr_l    = s_q.wr;
    assign busy    = (s_q.step != ST_IDLE);
    assign done    = s_q.done;
    assign ea      = s_q.ea;
    assign ea_bank = s_q.eabank;
    assign rd_data = s_q.rdata;

    // R10: a pending request keeps all its fields until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
            $stable(mem_bank) && $stable(mem_we) && $stable(mem_wdata)));

    // R10: completion is a single-cycle pulse with nothing outstanding
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R7: the data read goes to the value written back in the pre step
    p_pre_feeds_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_PRE && mem_ack) |=>
            (mem_req && !mem_we && mem_addr == $past(mem_wdata)));

    // R5: a post-update write targets the pointer cell in page zero
    p_post_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_DATA && mem_ack && has_post) |=>
            (mem_req && mem_we && mem_bank == BANK_PZ &&
             mem_addr == $past(first_addr)));

    // R11: latched fields do not move while a sequence runs
    p_fields_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(opd_l) && $stable(wr_l) && $stable(ind_l)));

endmodule

// File: rtl/pzag_top.sv
module pzag_top
    import pzag_pkg::*;
#(
    parameter int OPW = 10,
    parameter int AW  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [OPW-1:0]      opd,
    input  logic                ind_bit,
    input  logic                reg_bit,
    input  logic [AW-OPW-1:0]   pc_hi,
    input  logic                wr_dir,
    input  logic [AW-1:0]       wr_data,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [BANK_W-1:0]   mem_bank,
    output logic [AW-1:0]       mem_wdata,
    input  logic                mem_ack,
    input  logic [AW-1:0]       mem_rdata,
    output logic                busy,
    output logic                done,
    output logic [AW-1:0]       ea,
    output logic [BANK_W-1:0]   ea_bank,
    output logic [AW-1:0]       rd_data
);
    logic [OPW-1:0]    opd_l;
    logic              ind_l, reg_l, wr_l;
    logic [AW-OPW-1:0] pchi_l;
    logic [AW-1:0]     first_addr;
    logic [BANK_W-1:0] first_bank, sel_bank;
    logic              special, has_pre, has_post, post_up;

    pzag_decode #(.OPW(OPW), .AW(AW)) u_dec (
        .opd_l      (opd_l),
        .ind_l      (ind_l),
        .reg_l      (reg_l),
        .pchi_l     (pchi_l),
        .wr_l       (wr_l),
        .first_addr (first_addr),
        .first_bank (first_bank),
        .special    (special),
        .sel_bank   (sel_bank),
        .has_pre    (has_pre),
        .has_post   (has_post),
        .post_up    (post_up)
    );

    pzag_seq #(.OPW(OPW), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .opd        (opd),
        .ind_bit    (ind_bit),
        .reg_bit    (reg_bit),
        .pc_hi      (pc_hi),
        .wr_dir     (wr_dir),
        .wr_data    (wr_data),
        .first_addr (first_addr),
        .first_bank (first_bank),
        .special    (special),
        .sel_bank   (sel_bank),
        .has_pre    (has_pre),
        .has_post   (has_post),
        .post_up    (post_up),
        .opd_l      (opd_l),
        .ind_l      (ind_l),
        .reg_l      (reg_l),
        .pchi_l     (pchi_l),
        .wr_l       (wr_l),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_bank   (mem_bank),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .ea         (ea),
        .ea_bank    (ea_bank),
        .rd_data    (rd_data)
    );

    // R2: direct page-local access is tagged with the program bank
    p_direct_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !ind_l && !reg_l) |->
            (mem_bank == BANK_PROG && mem_addr[AW-1:OPW] == pchi_l));

endmodule

// File: tb/sim_pzag_top.sv
module sim_pzag_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [9:0]  opd = '0;
    logic        ind_bit = 1'b0, reg_bit = 1'b0, wr_dir = 1'b0;
    logic [5:0]  pc_hi = '0;
    logic [15:0] wr_data = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [2:0]  mem_bank;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, done;
    logic [15:0] ea, rd_data;
    logic [2:0]  ea_bank;

    pzag_top u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .opd(opd), .ind_bit(ind_bit),
        .reg_bit(reg_bit), .pc_hi(pc_hi), .wr_dir(wr_dir), .wr_data(wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_bank(mem_bank), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea),
        .ea_bank(ea_bank), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        we;
        logic [2:0]  bank;
        logic [15:0] addr;
        logic [15:0] wdata;
    } xact_t;

    xact_t       expq[$];
    logic [15:0] mem_m [int];
    int          checks = 0;
    int          failures = 0;
    int          ack_delay = 0;
    int          wait_cnt = 0;
    string       cur_tag = "R10";

    function automatic int key(input logic [2:0] b, input logic [15:0] a);
        return int'({13'd0, b, a});
    endfunction

    function automatic logic [15:0] rd(input logic [2:0] b, input logic [15:0] a);
        if (mem_m.exists(key(b, a))) return mem_m[key(b, a)];
        return 16'h0000;
    endfunction

    task automatic poke(input logic [2:0] b, input logic [15:0] a, input logic [15:0] v);
        mem_m[key(b, a)] = v;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [2:0] b,
                        input logic [15:0] a, input logic [15:0] d);
        xact_t x;
        x.we = we; x.bank = b; x.addr = a; x.wdata = we ? d : 16'h0;
        expq.push_back(x);
    endtask

    // Memory model and monitor: compares each acknowledged step with the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_ack) begin
                mem_ack  <= 1'b0;
                wait_cnt <= ack_delay;
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    xact_t got, want;
                    got.we = mem_we; got.bank = mem_bank; got.addr = mem_addr;
                    got.wdata = mem_we ? mem_wdata : 16'h0;
                    if (expq.size() == 0) begin
                        chk(1'b0, cur_tag, "unexpected request", {13'd0, got.bank, got.addr}, 32'h0);
                    end else begin
                        want = expq.pop_front();
                        chk(got == want, cur_tag, "step {we,bank,addr,wdata}",
                            {got.we, got.bank, got.addr[11:0], got.wdata},
                            {want.we, want.bank, want.addr[11:0], want.wdata});
                    end
                    if (mem_we) mem_m[key(mem_bank, mem_addr)] = mem_wdata;
                    mem_rdata <= rd(mem_bank, mem_addr);
                    mem_ack   <= 1'b1;
                end else begin
                    wait_cnt <= wait_cnt - 1;
                end
            end
        end
    end

    // Driver: predicts the step list from the requirements, then starts the op
    task automatic run_op(input string tag, input logic [9:0] o, input logic ind,
                          input logic rm, input logic [5:0] ph, input logic wr,
                          input logic [15:0] wd, input bit stray);
        logic [15:0] fa, p, e_ea, e_rd;
        logic [2:0]  fb, e_b, sb;
        logic        sp;
        logic [1:0]  tt;
        int          n;
        cur_tag = tag;
        fa = rm ? {6'd0, o} : {ph, o};
        fb = rm ? 3'd3 : 3'd0;
        sp = rm && ind && (o[9:8] == 2'b11);
        tt = o[7:6];
        sb = o[2:0];
        if (!ind) begin
            push(wr, fb, fa, wd); e_ea = fa; e_b = fb;
        end else begin
            p = rd(fb, fa);
            push(1'b0, fb, fa, 16'h0);
            if (!sp) begin
                push(wr, 3'd1, p, wd); e_ea = p; e_b = 3'd1;
            end else begin
                e_b = sb; e_ea = p;
                case (tt)
                    2'b00: push(wr, sb, p, wd);
                    2'b01: begin push(wr, sb, p, wd); push(1'b1, 3'd3, fa, p + 16'd1); end
                    2'b10: begin push(wr, sb, p, wd); push(1'b1, 3'd3, fa, p - 16'd1); end
                    default: begin
                        if (!wr) begin
                            push(1'b1, 3'd3, fa, p - 16'd1);
                            push(1'b0, sb, p - 16'd1, 16'h0);
                            e_ea = p - 16'd1;
                        end else begin
                            push(1'b1, sb, p, wd);
                            push(1'b1, 3'd3, fa, p + 16'd1);
                        end
                    end
                endcase
            end
        end
        e_rd = rd(e_b, e_ea);
        @(negedge clk);
        opd = o; ind_bit = ind; reg_bit = rm; pc_hi = ph; wr_dir = wr; wr_data = wd;
        go = 1'b1;
        @(negedge clk);
        if (stray) begin
            opd = 10'h3C7; ind_bit = 1'b1; reg_bit = 1'b1; wr_dir = ~wr;
            wr_data = 16'hDEAD; pc_hi = 6'h3F;
        end else begin
            go = 1'b0;
        end
        @(negedge clk);
        go = 1'b0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, tag, "done pulse seen", {31'd0, done}, 32'd1);
        chk(ea == e_ea && ea_bank == e_b, tag, "ea/ea_bank",
            {13'd0, ea_bank, ea}, {13'd0, e_b, e_ea});
        if (!wr) chk(rd_data == e_rd, tag, "rd_data", {16'd0, rd_data}, {16'd0, e_rd});
        chk(expq.size() == 0, tag, "all predicted steps issued", expq.size(), 32'd0);
        expq.delete();
        @(negedge clk);
        chk(done == 1'b0, "R10", "done lasts one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(mem_req == 1'b0 && busy == 1'b0 && done == 1'b0, "R10", "reset outputs",
            {29'd0, mem_req, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: direct page-zero read, also in the pointer-cell range
        poke(3'd3, 16'h02A5, 16'h1357);
        run_op("R1", 10'h2A5, 1'b0, 1'b1, 6'h15, 1'b0, 16'h0, 1'b0);
        poke(3'd3, 16'h0345, 16'hBEEF);
        run_op("R1", 10'h345, 1'b0, 1'b1, 6'h15, 1'b0, 16'h0, 1'b0);
        // R2: direct page-local write
        run_op("R2", 10'h123, 1'b0, 1'b0, 6'h15, 1'b1, 16'hA5A5, 1'b0);
        // R3: indirect via current page and via an ordinary page-zero cell
        poke(3'd0, {6'h15, 10'h040}, 16'h8123);
        poke(3'd1, 16'h8123, 16'h4242);
        run_op("R3", 10'h040, 1'b1, 1'b0, 6'h15, 1'b0, 16'h0, 1'b0);
        poke(3'd3, 16'h02FF, 16'h7000);
        ack_delay = 2;
        run_op("R3", 10'h2FF, 1'b1, 1'b1, 6'h00, 1'b1, 16'h0F0F, 1'b0);
        ack_delay = 0;
        // R4: plain pointer cell, bank 5
        poke(3'd3, 16'h0315, 16'h0AB0);
        poke(3'd5, 16'h0AB0, 16'hCAFE);
        run_op("R4", 10'h315, 1'b1, 1'b1, 6'h2A, 1'b0, 16'h0, 1'b0);
        // R5: post-increment write via bank 6
        poke(3'd3, 16'h034E, 16'h1000);
        run_op("R5", 10'h34E, 1'b1, 1'b1, 6'h00, 1'b1, 16'h5555, 1'b0);
        // R6: post-decrement read via bank 7
        poke(3'd3, 16'h0387, 16'h2000);
        poke(3'd7, 16'h2000, 16'h9999);
        ack_delay = 1;
        run_op("R6", 10'h387, 1'b1, 1'b1, 6'h00, 1'b0, 16'h0, 1'b0);
        ack_delay = 0;
        // R7/R8: stack pop, push, pop on one cell, bank 4
        poke(3'd3, 16'h03C4, 16'h0500);
        poke(3'd4, 16'h04FF, 16'h1111);
        run_op("R7", 10'h3C4, 1'b1, 1'b1, 6'h00, 1'b0, 16'h0, 1'b0);
        run_op("R8", 10'h3C4, 1'b1, 1'b1, 6'h00, 1'b1, 16'h7777, 1'b0);
        run_op("R7", 10'h3C4, 1'b1, 1'b1, 6'h00, 1'b0, 16'h0, 1'b0);
        // R9: wrap on increment, decrement and stack pre-decrement
        poke(3'd3, 16'h0340, 16'hFFFF);
        run_op("R9", 10'h340, 1'b1, 1'b1, 6'h00, 1'b0, 16'h0, 1'b0);
        poke(3'd3, 16'h0382, 16'h0000);
        run_op("R9", 10'h382, 1'b1, 1'b1, 6'h00, 1'b1, 16'h1234, 1'b0);
        poke(3'd3, 16'h03C3, 16'h0000);
        poke(3'd3, 16'hFFFF, 16'h6543);
        run_op("R9", 10'h3C3, 1'b1, 1'b1, 6'h00, 1'b0, 16'h0, 1'b0);
        // R11: stray start with different fields during a sequence
        poke(3'd3, 16'h0349, 16'h3000);
        ack_delay = 2;
        run_op("R11", 10'h349, 1'b1, 1'b1, 6'h00, 1'b1, 16'h4444, 1'b1);
        ack_delay = 0;
        quiet = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (mem_req) quiet++;
        end
        chk(quiet == 0, "R11", "no request after done", quiet, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule